// File: doc/BRIEF.md
# Gigabit PHY Control Register with Deferred Speed Commit

This block is the control word of a gigabit Ethernet PHY's management register set, with two status companions. Software reaches it through single-cycle read and write strobes carrying a register address and 16-bit data. Address 0 holds the configuration: speed, duplex, auto-negotiation enable, power down, isolate, loopback, collision test, a self-clearing restart and a self-clearing soft reset. Address 1 carries a latched-low link flag in bit 2. Address 10 carries an 8-bit saturating idle-error count in bits 7:0 that clears once it has been read.

Speed is written into a pending copy and reaches the active copy only when a commit event occurs. The active copy drives the PHY configuration outputs. A commit event is a soft reset, a restart request, or a write that takes power down from 1 to 0. While auto-negotiation is enabled, the speed and duplex outputs follow the negotiated values that the negotiation engine supplies. Collision test reaches its output only while loopback is on. Every restart request, and the first cycle after a hardware reset, produces a one-cycle restart pulse.

Top module: `phy_ctl_reg`

## Requirements
- R1: After hardware reset, the control word at address 0 reads 16'h1100 (auto-negotiation enable bit 12 = 1, full duplex bit 8 = 1, all other bits 0), and the active speed is 2'b00.
- R2: In the control word, bits 5:0, bit 9 (restart) and bit 15 (soft reset) always read 0. The remaining fields read back as stored: loopback bit 14, pending speed low bit 13, auto-negotiation enable bit 12, power down bit 11, isolate bit 10, duplex bit 8, collision test bit 7, pending speed high bit 6.
- R3: A write that changes the speed code {bit 6, bit 13} updates only the pending copy. The active speed keeps its value until a commit event.
- R4: A commit event copies the speed code written in the same word to the active speed. The three commit events are a write with bit 15 = 1, a write with bit 9 = 1, and a write that clears bit 11 while it is 1.
- R5: Speed code 2'b11 is stored and read back in the pending copy, but a commit event never moves it to the active speed.
- R6: While auto-negotiation is enabled, cfg_speed and cfg_full_dup equal neg_speed and neg_full_dup. Otherwise they equal the active speed and the stored duplex bit.
- R7: cfg_col_test is 1 only when both collision test and loopback are stored as 1.
- R8: aneg_restart is high for exactly the one cycle after each control write with bit 9 or bit 15 set. It is also high in the first cycle after hardware reset is released.
- R9: A control write with bit 15 set reloads every field except the pending speed to its reset value. The pending speed takes the written code.
- R10: The link flag (address 1, bit 2) resets to 0 and goes to 0 in any cycle in which link_live is 0. It then stays 0 until the status word is read. A read loads the live link value on the following edge.
- R11: The error count at address 10 adds one per idle_err cycle and saturates at 255. On the edge after a read it becomes 1 if idle_err is high in the read cycle, and 0 otherwise.
- R12: Writes to addresses other than 0 change no state. Reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| mgmt_wr | input | 1 | Write strobe, one access per cycle |
| mgmt_rd | input | 1 | Read strobe; triggers the read side effects |
| mgmt_addr | input | 5 | Register address |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data for mgmt_addr, combinational |
| link_live | input | 1 | Live link-good indication |
| idle_err | input | 1 | One idle error per high cycle |
| neg_speed | input | 2 | Speed code chosen by auto-negotiation |
| neg_full_dup | input | 1 | Duplex chosen by auto-negotiation |
| cfg_speed | output | 2 | Speed in effect (10 = 1000, 01 = 100, 00 = 10 Mb/s) |
| cfg_full_dup | output | 1 | Duplex in effect |
| cfg_aneg_en | output | 1 | Auto-negotiation enabled |
| cfg_pwr_down | output | 1 | Power down |
| cfg_loopback | output | 1 | Loopback |
| cfg_col_test | output | 1 | Collision signal test |
| aneg_restart | output | 1 | One-cycle auto-negotiation restart pulse |

## Verification
The assertions take for granted that the strobes are synchronous to clk and that a read's side effects belong to the cycle in which mgmt_rd is high. They make no assumption about how often reads, writes, error pulses or link drops arrive. A control write may combine soft reset, restart and a power-down exit in any mix. The stimulus has a directed part that walks each commit path and the reserved speed code. A random part then drives arbitrary words, addresses, link drops and error bursts every cycle against the reference model. Both parts toggle rst_n only at the start.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

  localparam int REG_W = 16;

  localparam int B_SWRST   = 15;
  localparam int B_LOOP    = 14;
  localparam int B_SPD_LSB = 13;
  localparam int B_ANEG    = 12;
  localparam int B_PDOWN   = 11;
  localparam int B_ISO     = 10;
  localparam int B_RESTART = 9;
  localparam int B_DUPLEX  = 8;
  localparam int B_COLTEST = 7;
  localparam int B_SPD_MSB = 6;

  localparam logic [1:0] SPD_RESERVED = 2'b11;

  typedef struct packed {
    logic       loopback;
    logic       aneg_en;
    logic       pwr_down;
    logic       isolate;
    logic       full_dup;
    logic       col_test;
    logic [1:0] pend_spd;
  } ctl_t;

  localparam ctl_t CTL_DEFAULT = '{loopback: 1'b0, aneg_en: 1'b1, pwr_down: 1'b0,
                                   isolate: 1'b0, full_dup: 1'b1, col_test: 1'b0,
                                   pend_spd: 2'b00};

  // speed code is split: high half in bit 6, low half in bit 13
  function automatic logic [1:0] spd_of_word(input logic [REG_W-1:0] w);
    return {w[B_SPD_MSB], w[B_SPD_LSB]};
  endfunction

  function automatic ctl_t ctl_of_word(input logic [REG_W-1:0] w);
    ctl_t c;
    c.loopback = w[B_LOOP];
    c.aneg_en  = w[B_ANEG];
    c.pwr_down = w[B_PDOWN];
    c.isolate  = w[B_ISO];
    c.full_dup = w[B_DUPLEX];
    c.col_test = w[B_COLTEST];
    c.pend_spd = spd_of_word(w);
    return c;
  endfunction

  function automatic logic [REG_W-1:0] word_of_ctl(input ctl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_LOOP]    = c.loopback;
    w[B_ANEG]    = c.aneg_en;
    w[B_PDOWN]   = c.pwr_down;
    w[B_ISO]     = c.isolate;
    w[B_DUPLEX]  = c.full_dup;
    w[B_COLTEST] = c.col_test;
    w[B_SPD_MSB] = c.pend_spd[1];
    w[B_SPD_LSB] = c.pend_spd[0];
    return w;
  endfunction

  function automatic logic spd_committable(input logic [1:0] s);
    return s != SPD_RESERVED;
  endfunction

endpackage

// File: rtl/phy_ctl_core.sv
module phy_ctl_core
  import phy_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wdata,
  output ctl_t             ctl,
  output logic [1:0]       act_spd,
  output logic             restart_pulse,
  output logic             commit_evt
);

  ctl_t       ctl_nxt;
  logic       boot_flag;
  logic       req_restart;
  logic       pd_exit;
  logic [1:0] commit_spd;
  logic       unused_lowbits;

  assign unused_lowbits = ^wdata[5:0];
  assign commit_spd     = spd_of_word(wdata);

  always_comb begin
    ctl_nxt     = ctl;
    req_restart = 1'b0;
    pd_exit     = 1'b0;
    if (wr_hit) begin
      ctl_nxt = ctl_of_word(wdata);
      if (wdata[B_SWRST]) begin
        ctl_nxt          = CTL_DEFAULT;
        ctl_nxt.pend_spd = commit_spd;
      end
      pd_exit     = ctl.pwr_down && !ctl_nxt.pwr_down;
      req_restart = wdata[B_SWRST] || wdata[B_RESTART];
    end
  end

  assign commit_evt = req_restart || pd_exit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl           <= CTL_DEFAULT;
      act_spd       <= CTL_DEFAULT.pend_spd;
      restart_pulse <= 1'b0;
      boot_flag     <= 1'b1;
    end else begin
      ctl           <= ctl_nxt;
      restart_pulse <= req_restart || boot_flag;
      boot_flag     <= 1'b0;
      if (commit_evt && spd_committable(commit_spd))
        act_spd <= commit_spd;
    end
  end

  // R3: active speed moves only on the edge that saw a commit event
  assert_speed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_spd) |-> $past(commit_evt));

  // R5: the reserved code never becomes active
  assert_no_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_spd != SPD_RESERVED);

  // R8: every restart request yields the pulse on the next cycle
  assert_restart_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_restart |=> restart_pulse);

  // R9: soft reset restores the defaults of the non-speed fields
  assert_swrst_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wdata[B_SWRST]) |=>
      (ctl.aneg_en && ctl.full_dup && !ctl.pwr_down && !ctl.loopback &&
       !ctl.col_test && !ctl.isolate));

endmodule

// File: rtl/phy_link_latch.sv
module phy_link_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_hit,
  input  logic link_live,
  output logic link_lat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          link_lat <= 1'b0;
    else if (rd_hit)     link_lat <= link_live;
    else if (!link_live) link_lat <= 1'b0;
  end

  // R10: a loss outside a read always latches low
  assert_link_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hit && !link_live) |=> !link_lat);

  // R10: a latched low is held until a read
  assert_link_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hit && !link_lat) |=> !link_lat);

endmodule

// File: rtl/phy_err_count.sv
module phy_err_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_hit,
  input  logic             err_evt,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c, input logic e);
    if (e && c != CNT_MAX) return c + 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (rd_hit) cnt <= {{(CNT_W-1){1'b0}}, err_evt};
    else             cnt <= bump(cnt, err_evt);
  end

  // R11: a read empties the counter
  assert_cnt_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (cnt <= 1));

  // R11: the counter saturates instead of wrapping
  assert_cnt_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !rd_hit) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/phy_ctl_reg.sv
module phy_ctl_reg
  import phy_ctl_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int CNT_ADDR  = 10,
  parameter int CNT_W     = 8,
  parameter int LINK_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgmt_wr,
  input  logic              mgmt_rd,
  input  logic [ADDR_W-1:0] mgmt_addr,
  input  logic [REG_W-1:0]  mgmt_wdata,
  output logic [REG_W-1:0]  mgmt_rdata,
  input  logic              link_live,
  input  logic              idle_err,
  input  logic [1:0]        neg_speed,
  input  logic              neg_full_dup,
  output logic [1:0]        cfg_speed,
  output logic              cfg_full_dup,
  output logic              cfg_aneg_en,
  output logic              cfg_pwr_down,
  output logic              cfg_loopback,
  output logic              cfg_col_test,
  output logic              aneg_restart
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(CNT_ADDR);

  logic             ctrl_wr_hit;
  logic             stat_rd_hit;
  logic             cnt_rd_hit;
  ctl_t             ctl;
  logic [1:0]       act_spd;
  logic             commit_evt;
  logic             link_lat;
  logic [CNT_W-1:0] err_cnt;
  logic [REG_W-1:0] stat_word;
  logic             unused_commit;

  assign ctrl_wr_hit   = mgmt_wr && (mgmt_addr == A_CTRL);
  assign stat_rd_hit   = mgmt_rd && (mgmt_addr == A_STAT);
  assign cnt_rd_hit    = mgmt_rd && (mgmt_addr == A_CNT);
  assign unused_commit = commit_evt;

  phy_ctl_core u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_hit        (ctrl_wr_hit),
    .wdata         (mgmt_wdata),
    .ctl           (ctl),
    .act_spd       (act_spd),
    .restart_pulse (aneg_restart),
    .commit_evt    (commit_evt)
  );

  phy_link_latch u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_hit    (stat_rd_hit),
    .link_live (link_live),
    .link_lat  (link_lat)
  );

  phy_err_count #(.CNT_W(CNT_W)) u_errs (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_hit  (cnt_rd_hit),
    .err_evt (idle_err),
    .cnt     (err_cnt)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[LINK_BIT] = link_lat;
  end

  always_comb begin
    if (mgmt_addr == A_CTRL)      mgmt_rdata = word_of_ctl(ctl);
    else if (mgmt_addr == A_STAT) mgmt_rdata = stat_word;
    else if (mgmt_addr == A_CNT)  mgmt_rdata = {{(REG_W-CNT_W){1'b0}}, err_cnt};
    else                          mgmt_rdata = '0;
  end

  // auto-negotiation overrides the manual speed and duplex
  assign cfg_speed    = ctl.aneg_en ? neg_speed    : act_spd;
  assign cfg_full_dup = ctl.aneg_en ? neg_full_dup : ctl.full_dup;
  assign cfg_aneg_en  = ctl.aneg_en;
  assign cfg_pwr_down = ctl.pwr_down;
  assign cfg_loopback = ctl.loopback;
  assign cfg_col_test = ctl.col_test && ctl.loopback;

  // R2: the action and reserved bits never read back as 1
  assert_ro_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_addr == A_CTRL) |->
      (mgmt_rdata[5:0] == 6'd0 && !mgmt_rdata[B_RESTART] && !mgmt_rdata[B_SWRST]));

  // R12: a write elsewhere leaves the control outputs untouched
  assert_other_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_wr && mgmt_addr != A_CTRL) |=>
      ($stable(cfg_aneg_en) && $stable(cfg_pwr_down) && $stable(cfg_loopback) && !aneg_restart));

endmodule

// File: tb/phy_ctl_reg_test.sv
module phy_ctl_reg_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mgmt_wr = 1'b0, mgmt_rd = 1'b0;
  logic [4:0]  mgmt_addr = '0;
  logic [15:0] mgmt_wdata = '0;
  logic [15:0] mgmt_rdata;
  logic        link_live = 1'b1, idle_err = 1'b0;
  logic [1:0]  neg_speed = 2'b10;
  logic        neg_full_dup = 1'b1;
  logic [1:0]  cfg_speed;
  logic        cfg_full_dup, cfg_aneg_en, cfg_pwr_down, cfg_loopback, cfg_col_test, aneg_restart;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phy_ctl_reg uut (.*);

  // reference model state
  logic [1:0] m_pend, m_act;
  logic m_dup, m_an, m_pd, m_iso, m_lb, m_col, m_pulse, m_boot, m_link;
  int   m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 2'b00; m_act = 2'b00; m_dup = 1; m_an = 1; m_pd = 0; m_iso = 0;
      m_lb = 0; m_col = 0; m_pulse = 0; m_boot = 1; m_link = 0; m_cnt = 0;
    end else begin
      logic nr, sw, was_pd;
      logic [1:0] s;
      nr = m_boot;
      m_boot = 0;
      if (mgmt_wr && mgmt_addr == 5'd0) begin
        s = {mgmt_wdata[6], mgmt_wdata[13]};
        sw = mgmt_wdata[15];
        was_pd = m_pd;
        m_pend = s;
        if (sw) begin
          m_dup = 1; m_an = 1; m_pd = 0; m_iso = 0; m_lb = 0; m_col = 0;
        end else begin
          m_dup = mgmt_wdata[8]; m_an = mgmt_wdata[12]; m_pd = mgmt_wdata[11];
          m_iso = mgmt_wdata[10]; m_lb = mgmt_wdata[14]; m_col = mgmt_wdata[7];
        end
        if ((sw || mgmt_wdata[9] || (was_pd && !m_pd)) && s != 2'b11) m_act = s;
        if (sw || mgmt_wdata[9]) nr = 1;
      end
      if (mgmt_rd && mgmt_addr == 5'd1) m_link = link_live;
      else if (!link_live)              m_link = 0;
      if (mgmt_rd && mgmt_addr == 5'd10) m_cnt = idle_err ? 1 : 0;
      else if (idle_err && m_cnt < 255)  m_cnt = m_cnt + 1;
      m_pulse = nr;
    end
  end

  function automatic logic [15:0] exp_rdata(input logic [4:0] a);
    case (a)
      5'd0:    return {1'b0, m_lb, m_pend[0], m_an, m_pd, m_iso, 1'b0, m_dup, m_col, m_pend[1], 6'b0};
      5'd1:    return {13'b0, m_link, 2'b0};
      5'd10:   return 16'(m_cnt);
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3/R6 cfg_speed", 16'(cfg_speed), 16'(m_an ? neg_speed : m_act));
      check("R6 cfg_full_dup", 16'(cfg_full_dup), 16'(m_an ? neg_full_dup : m_dup));
      check("R7 cfg_col_test", 16'(cfg_col_test), 16'(m_col & m_lb));
      check("R8 aneg_restart", 16'(aneg_restart), 16'(m_pulse));
      check("R9 cfg fields", {13'b0, cfg_aneg_en, cfg_pwr_down, cfg_loopback}, {13'b0, m_an, m_pd, m_lb});
      check("R2 mgmt_rdata", mgmt_rdata, exp_rdata(mgmt_addr));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    mgmt_wr = 1; mgmt_addr = a; mgmt_wdata = d;
    @(posedge clk); #1;
    mgmt_wr = 0; mgmt_addr = 5'd0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    @(posedge clk); #1;
    mgmt_rd = 1; mgmt_addr = a;
    #1 v = mgmt_rdata;
    @(posedge clk); #1;
    mgmt_rd = 0; mgmt_addr = 5'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("watchdog expired at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    check("R8 restart after hw reset", 16'(aneg_restart), 16'h1);
    @(posedge clk); #1;
    check("R8 pulse is one cycle", 16'(aneg_restart), 16'h0);
    rd(5'd0, v); check("R1 reset control word", v, 16'h1100);

    wr(5'd0, 16'h0040);
    #1 check("R3 speed held pending", 16'(cfg_speed), 16'h0);
    rd(5'd0, v); check("R2 readback", v, 16'h0040);
    wr(5'd0, 16'h0240);
    #1 check("R8 pulse after restart write", 16'(aneg_restart), 16'h1);
    check("R4 restart commits speed", 16'(cfg_speed), 16'h2);

    wr(5'd0, 16'h2040);
    wr(5'd0, 16'h2240);
    #1 check("R5 reserved not committed", 16'(cfg_speed), 16'h2);
    rd(5'd0, v); check("R5 reserved kept pending", v, 16'h2040);

    wr(5'd0, 16'h2800);
    #1 check("R3 power-down write holds speed", 16'(cfg_speed), 16'h2);
    wr(5'd0, 16'h2000);
    #1 check("R4 power-up exit commits", 16'(cfg_speed), 16'h1);

    neg_speed = 2'b10; neg_full_dup = 1'b1;
    wr(5'd0, 16'h1000);
    #1 check("R6 negotiated speed", 16'(cfg_speed), 16'h2);
    neg_speed = 2'b00; neg_full_dup = 1'b0;
    #1 check("R6 negotiated duplex", {14'b0, cfg_speed, cfg_full_dup} , 16'h0);

    wr(5'd0, 16'h0080);
    #1 check("R7 col test gated off", 16'(cfg_col_test), 16'h0);
    wr(5'd0, 16'h4080);
    #1 check("R7 col test with loopback", 16'(cfg_col_test), 16'h1);

    wr(5'd0, 16'hC840);
    #1 check("R8 pulse after soft reset", 16'(aneg_restart), 16'h1);
    rd(5'd0, v); check("R9 soft reset defaults", v, 16'h1140);
    wr(5'd0, 16'h0040);
    #1 check("R4 soft reset committed speed", 16'(cfg_speed), 16'h2);

    wr(5'd1, 16'hFFFF);
    wr(5'd3, 16'hFFFF);
    rd(5'd0, v); check("R12 other writes ignored", v, 16'h0040);
    rd(5'd7, v); check("R12 unused address reads 0", v, 16'h0000);

    rd(5'd1, v); check("R10 latched low from reset", v, 16'h0000);
    rd(5'd1, v); check("R10 live after read", v, 16'h0004);
    @(posedge clk); #1 link_live = 0;
    @(posedge clk); #1 link_live = 1;
    repeat (3) @(posedge clk);
    rd(5'd1, v); check("R10 loss held until read", v, 16'h0000);
    rd(5'd1, v); check("R10 recovers after read", v, 16'h0004);

    rd(5'd10, v);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1 idle_err = 1;
      @(posedge clk); #1 idle_err = 0;
    end
    rd(5'd10, v); check("R11 error count", v, 16'h0003);
    rd(5'd10, v); check("R11 cleared after read", v, 16'h0000);
    @(posedge clk); #1 idle_err = 1;
    repeat (300) @(posedge clk);
    #1 idle_err = 0;
    rd(5'd10, v); check("R11 saturation", v, 16'h00FF);

    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      mgmt_wr      = ($urandom % 4) == 0;
      mgmt_rd      = ($urandom % 3) == 0;
      mgmt_addr    = ($urandom % 2) ? 5'd0 : 5'($urandom % 12);
      mgmt_wdata   = 16'($urandom);
      if (($urandom % 8) != 0) mgmt_wdata[15] = 1'b0;
      link_live    = ($urandom % 6) != 0;
      idle_err     = ($urandom % 3) == 0;
      neg_speed    = 2'($urandom);
      neg_full_dup = 1'($urandom);
    end
    @(posedge clk); #1;
    mgmt_wr = 0; mgmt_rd = 0;
    repeat (2) @(posedge clk);
    #1 done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule